// File: doc/BRIEF.md
# Dual Switching-Converter Pulse Driver

This block produces two fixed-frequency pulse trains that drive the power switches of two external DC-DC converters. A shared prescaler divides the system clock into slot ticks. Sixteen slots make one drive period, so with a divider chosen for 16 × 96 kHz the drive outputs run at 96 kHz. Each channel turns its output on for a programmable number of sixteenths of that period, from one to fifteen, starting at the first slot.

Each channel has its own enable, on-time value, polarity select and feedback input. The polarity select picks an active-high drive for a positive converter or an active-low drive for a negative one. The feedback input comes from a comparator that watches the regulated voltage. It passes through a two-flop synchroniser. If it is high at the start of a period, that whole period produces no pulse. Enable, on-time, polarity and feedback are captured only at a period boundary, so a change in the middle of a period never cuts a pulse short. No stream of data passes through the block, so it has no valid/ready handshake. Every port is a plain level-sensitive control or status pin.

Top module: `dcdc_pwm_pair`

## Requirements
- R1: The two channels work independently. The settings and feedback of one channel never change the output of the other.
- R2: A slot tick fires once every `slot_div` system clocks, and a `slot_div` of 0 acts as 1. One drive period is 16 slots, so the output repeats every 16 × `slot_div` clocks.
- R3: With enable set, feedback low and an on-time value d from 1 to 15, a channel is active for the first d slots of each period and inactive for the other 16 − d slots.
- R4: An on-time value of 0 holds the channel at its inactive level for the whole period.
- R5: Polarity 0 makes the active level high and the inactive level low. Polarity 1 makes the active level low and the inactive level high.
- R6: With enable clear, the channel stays at its inactive level, and that level still follows its polarity.
- R7: Feedback passes through two flip-flops. If the synchronised feedback is high when a period starts, the channel stays inactive for that whole period. The other channel is not affected.
- R8: A change to enable, on-time or polarity during a period first shows in the next period. The pulse already in progress keeps its old length.
- R9: During reset and until the first period boundary after reset, both outputs are low.
- R10: A drive output changes level only at a slot boundary, so every high or low run lasts a whole number of slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slot_div | input | 16 | System clocks per slot tick (0 acts as 1) |
| ch_en | input | 2 | Enable for each channel, bit i for channel i |
| ch_duty | input | 8 | On-time in sixteenths; bits 4i+3:4i belong to channel i |
| ch_pol | input | 2 | Polarity for each channel; 1 selects active-low drive |
| fb_in | input | 2 | Asynchronous feedback for each channel; high suppresses pulses |
| drive | output | 2 | Drive output for each channel |

## Verification
The bench counts high cycles over windows that are whole multiples of the period, so a miscounted slot shows up as a wrong total. This covers on-time values 1 and 15 and a divider of 0. A design that inverted the polarity only on active slots, or let a disabled or zero on-time channel float to the active level, would give full or empty counts where the opposite is expected. An on-time change is made while a pulse is high. A design that applied it at once would stretch that pulse to the new length instead of finishing the old one. Holding feedback on one channel must silence that channel fully while leaving the other channel's count unchanged.

// File: rtl/dcdc_pwm_pkg.sv
package dcdc_pwm_pkg;
  localparam int SLOT_W = 4;
  localparam int SLOTS  = 1 << SLOT_W;

  typedef logic [SLOT_W-1:0] slot_t;

  // settings a channel holds for one whole period
  typedef struct packed {
    logic  en;
    logic  pol;
    logic  fb;
    slot_t duty;
  } ch_cfg_t;
endpackage

// File: rtl/pwm_slot_timer.sv
module pwm_slot_timer
  import dcdc_pwm_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o,
  output slot_t            slot_o,
  output logic             wrap_o
);
  logic [DIV_W-1:0] pre_q;
  logic [DIV_W-1:0] div_eff;
  slot_t            slot_q;

  // a zero divider behaves as one clock per slot
  assign div_eff = (div_i == '0) ? {{(DIV_W-1){1'b0}}, 1'b1} : div_i;
  // >= keeps the prescaler bounded when the divider shrinks mid-count
  assign tick_o  = (pre_q >= div_eff - 1'b1);
  assign wrap_o  = tick_o && (slot_q == slot_t'(SLOTS - 1));
  assign slot_o  = slot_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      slot_q <= '0;
    end else if (tick_o) begin
      pre_q  <= '0;
      slot_q <= slot_q + 1'b1;
    end else begin
      pre_q  <= pre_q + 1'b1;
    end
  end
endmodule

// File: rtl/pwm_fb_sync.sv
module pwm_fb_sync #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= async_i;
      sync_q <= meta_q;
    end
  end

  assign sync_o = sync_q;
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
  import dcdc_pwm_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    wrap_i,
  input  slot_t   slot_i,
  input  logic    en_i,
  input  logic    pol_i,
  input  slot_t   duty_i,
  input  logic    fb_i,
  output logic    drive_o,
  output ch_cfg_t cfg_o
);
  ch_cfg_t cfg_q;
  logic    active;
  logic    drive_q;

  // capture settings only at the period boundary
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (wrap_i) begin
      cfg_q.en   <= en_i;
      cfg_q.pol  <= pol_i;
      cfg_q.fb   <= fb_i;
      cfg_q.duty <= duty_i;
    end
  end

  always_comb begin
    active = cfg_q.en && !cfg_q.fb && (cfg_q.duty != '0) && (slot_i < cfg_q.duty);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) drive_q <= 1'b0;
    else        drive_q <= active ^ cfg_q.pol;
  end

  assign drive_o = drive_q;
  assign cfg_o   = cfg_q;
endmodule

// File: rtl/dcdc_pwm_pair.sv
module dcdc_pwm_pair
  import dcdc_pwm_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int DIV_W  = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [DIV_W-1:0]         slot_div,
  input  logic [NUM_CH-1:0]        ch_en,
  input  logic [NUM_CH*SLOT_W-1:0] ch_duty,
  input  logic [NUM_CH-1:0]        ch_pol,
  input  logic [NUM_CH-1:0]        fb_in,
  output logic [NUM_CH-1:0]        drive
);
  logic                     slot_tick;
  logic                     period_wrap;
  slot_t                    slot_idx;
  logic [NUM_CH-1:0]        fb_sync;
  logic [NUM_CH-1:0]        held_pol;
  logic [NUM_CH-1:0]        held_fb;
  logic [NUM_CH*SLOT_W-1:0] held_duty;

  pwm_slot_timer #(.DIV_W(DIV_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .div_i  (slot_div),
    .tick_o (slot_tick),
    .slot_o (slot_idx),
    .wrap_o (period_wrap)
  );

  pwm_fb_sync #(.W(NUM_CH)) u_fbsync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (fb_in),
    .sync_o  (fb_sync)
  );

  for (genvar gi = 0; gi < NUM_CH; gi++) begin : g_ch
    ch_cfg_t cfg_w;
    pwm_channel u_ch (
      .clk     (clk),
      .rst_n   (rst_n),
      .wrap_i  (period_wrap),
      .slot_i  (slot_idx),
      .en_i    (ch_en[gi]),
      .pol_i   (ch_pol[gi]),
      .duty_i  (ch_duty[gi*SLOT_W +: SLOT_W]),
      .fb_i    (fb_sync[gi]),
      .drive_o (drive[gi]),
      .cfg_o   (cfg_w)
    );
    assign held_pol[gi]                   = cfg_w.pol;
    assign held_fb[gi]                    = cfg_w.fb;
    assign held_duty[gi*SLOT_W +: SLOT_W] = cfg_w.duty;
  end
endmodule

// File: rtl/dcdc_pwm_chk.sv
module dcdc_pwm_chk
  import dcdc_pwm_pkg::*;
#(
  parameter int NUM_CH = 2
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     slot_tick,
  input logic                     period_wrap,
  input slot_t                    slot_idx,
  input logic [NUM_CH-1:0]        fb_in,
  input logic [NUM_CH-1:0]        fb_sync,
  input logic [NUM_CH-1:0]        held_pol,
  input logic [NUM_CH-1:0]        held_fb,
  input logic [NUM_CH*SLOT_W-1:0] held_duty,
  input logic [NUM_CH-1:0]        drive
);
  logic [1:0] age_q;
  logic       warm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 1'b1;
  end
  assign warm = (age_q >= 2'd2);

  assert_slot_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && $past(slot_tick)) |-> (slot_idx == slot_t'($past(slot_idx) + 1'b1)));

  assert_slot_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && !$past(slot_tick)) |-> $stable(slot_idx));

  for (genvar gi = 0; gi < NUM_CH; gi++) begin : g_a
    assert_fb_sync_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (age_q == 2'd3) |-> (fb_sync[gi] == $past(fb_in[gi], 2)));

    assert_fb_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (warm && $past(held_fb[gi])) |-> (drive[gi] == $past(held_pol[gi])));

    assert_zero_duty_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (warm && $past(held_duty[gi*SLOT_W +: SLOT_W] == '0)) |-> (drive[gi] == $past(held_pol[gi])));

    assert_shadow_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (warm && !$past(period_wrap)) |->
        ($stable(held_duty[gi*SLOT_W +: SLOT_W]) && $stable(held_pol[gi])));

    assert_edge_on_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (warm && (drive[gi] != $past(drive[gi]))) |-> $past(slot_tick, 2));
  end
endmodule

bind dcdc_pwm_pair dcdc_pwm_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .slot_tick   (slot_tick),
  .period_wrap (period_wrap),
  .slot_idx    (slot_idx),
  .fb_in       (fb_in),
  .fb_sync     (fb_sync),
  .held_pol    (held_pol),
  .held_fb     (held_fb),
  .held_duty   (held_duty),
  .drive       (drive)
);

// File: tb/sim_dcdc_pwm_pair.sv
module sim_dcdc_pwm_pair;
  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 4;
  localparam int PER        = 16 * DIV;
  localparam int WIN        = 4 * PER;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] slot_div = 16'(DIV);
  logic [1:0]  ch_en = '0;
  logic [7:0]  ch_duty = '0;
  logic [1:0]  ch_pol = '0;
  logic [1:0]  fb_in = '0;
  logic [1:0]  drive;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dcdc_pwm_pair u0 (
    .clk(clk), .rst_n(rst_n), .slot_div(slot_div), .ch_en(ch_en),
    .ch_duty(ch_duty), .ch_pol(ch_pol), .fb_in(fb_in), .drive(drive)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_ch(input int ch, input bit en, input bit pol, input int duty);
    ch_en[ch]          = en;
    ch_pol[ch]         = pol;
    ch_duty[ch*4 +: 4] = 4'(duty);
  endtask

  task automatic settle();
    repeat (3 * PER) @(negedge clk);
  endtask

  task automatic count_hi(input int ncyc, output int h0, output int h1);
    h0 = 0; h1 = 0;
    repeat (ncyc) begin
      @(negedge clk);
      if (drive[0]) h0++;
      if (drive[1]) h1++;
    end
  endtask

  task automatic wait_rise0();
    do @(negedge clk); while (drive[0]);
    do @(negedge clk); while (!drive[0]);
  endtask

  task automatic t_reset();
    int h0, h1;
    set_ch(1, 1'b1, 1'b1, 0);
    repeat (3) @(negedge clk);
    check("R9 output low in reset", int'(drive), 0);
    rst_n = 1'b1;
    count_hi(PER / 2, h0, h1);
    check("R9 first period low ch1", h1, 0);
    check("R9 first period low ch0", h0, 0);
  endtask

  task automatic t_basic();
    int h0, h1;
    set_ch(0, 1, 0, 5); set_ch(1, 1, 0, 11);
    settle(); count_hi(WIN, h0, h1);
    check("R3 duty 5 ch0", h0, 4 * 5 * DIV);
    check("R1 duty 11 ch1", h1, 4 * 11 * DIV);
  endtask

  task automatic t_edges();
    int h0, h1;
    set_ch(0, 1, 0, 1); set_ch(1, 1, 0, 15);
    settle(); count_hi(WIN, h0, h1);
    check("R3 duty 1", h0, 4 * 1 * DIV);
    check("R3 duty 15", h1, 4 * 15 * DIV);
  endtask

  task automatic t_period();
    int n;
    set_ch(0, 1, 0, 5);
    settle(); wait_rise0();
    n = 0;
    do begin @(negedge clk); n++; end while (drive[0]);
    do begin @(negedge clk); n++; end while (!drive[0]);
    check("R2 period div 4", n, PER);
    slot_div = 16'd3;
    settle(); wait_rise0();
    n = 0;
    do begin @(negedge clk); n++; end while (drive[0]);
    do begin @(negedge clk); n++; end while (!drive[0]);
    check("R2 period div 3", n, 48);
    slot_div = 16'd0;
    settle(); wait_rise0();
    n = 0;
    do begin @(negedge clk); n++; end while (drive[0]);
    do begin @(negedge clk); n++; end while (!drive[0]);
    check("R2 period div 0 acts as 1", n, 16);
    slot_div = 16'(DIV);
  endtask

  task automatic t_zero();
    int h0, h1;
    set_ch(0, 1, 0, 0); set_ch(1, 1, 0, 7);
    settle(); count_hi(WIN, h0, h1);
    check("R4 duty 0 inactive", h0, 0);
    check("R1 other channel unaffected", h1, 4 * 7 * DIV);
  endtask

  task automatic t_pol();
    int h0, h1;
    set_ch(0, 1, 1, 5); set_ch(1, 1, 1, 0);
    settle(); count_hi(WIN, h0, h1);
    check("R5 active-low duty 5", h0, 4 * 11 * DIV);
    check("R5 R4 active-low duty 0 idles high", h1, WIN);
  endtask

  task automatic t_enable();
    int h0, h1;
    set_ch(0, 0, 0, 9); set_ch(1, 0, 1, 9);
    settle(); count_hi(WIN, h0, h1);
    check("R6 disabled active-high", h0, 0);
    check("R6 disabled active-low", h1, WIN);
  endtask

  task automatic t_feedback();
    int h0, h1;
    set_ch(0, 1, 0, 5); set_ch(1, 1, 0, 11);
    fb_in = 2'b01;
    settle(); count_hi(WIN, h0, h1);
    check("R7 feedback silences ch0", h0, 0);
    check("R7 R1 ch1 keeps pulsing", h1, 4 * 11 * DIV);
    fb_in = 2'b00;
    settle(); count_hi(WIN, h0, h1);
    check("R7 pulses resume", h0, 4 * 5 * DIV);
  endtask

  task automatic t_shadow();
    int n;
    set_ch(0, 1, 0, 4);
    settle(); wait_rise0();
    n = 1;
    @(negedge clk); n++;
    set_ch(0, 1, 0, 12);
    while (drive[0]) begin @(negedge clk); if (drive[0]) n++; end
    check("R8 R10 running pulse keeps old length", n, 4 * DIV);
    do @(negedge clk); while (!drive[0]);
    n = 1;
    do begin @(negedge clk); if (drive[0]) n++; end while (drive[0]);
    check("R8 R10 next pulse uses new length", n, 12 * DIV);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_edges();
    t_period();
    t_zero();
    t_pol();
    t_enable();
    t_feedback();
    t_shadow();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule